// File: doc/BRIEF.md
# Instruction Fetch and Effective Address Sequencer

This block is the front end of a 16-bit processor. It pulls instruction words from memory through a request/acknowledge port and computes the effective address of each instruction. It then presents that address with the instruction's opcode and format bit and raises a one-clock completion strobe. There are two instruction formats. A one-word instruction carries a signed 8-bit displacement that is added to a base register. A two-word instruction carries a full address word, which may be indexed. The indexed result may itself be used as a pointer for one further memory read.

The sequencer holds its own instruction counter and three index registers, and it advances the counter after every word it fetches. An external load port writes the counter or any index register. Memory locations are 15 bits wide, and every address that is formed wraps modulo 2^15. The block has no execute stage. Once the strobe is given, it starts fetching the next instruction at once.

Top module: `ifa_seq`

## Requirements
- R1: With instruction bits numbered 15 (left) down to 0, the opcode is bits 15..11 and the format flag is bit 10 (0 = one word, 1 = two words). The index tag is bits 9..8. For two-word instructions, bit 7 is the indirect flag. For one-word instructions, bits 7..0 are the displacement. `op_o` and `fmt_o` show the first word's fields while `done_o` is high.
- R2: Each instruction's first word is requested at the instruction counter, and the counter then advances by one. A two-word instruction requests its address word at the next location and advances the counter again. A request is held, with its address unchanged, until it is acknowledged.
- R3: For a one-word instruction with tag 0, the effective address is the already advanced counter plus the sign-extended displacement (range -128..+127).
- R4: For a one-word instruction with tag 1, 2 or 3, the effective address is index register 1, 2 or 3 plus the sign-extended displacement.
- R5: For a two-word instruction with tag 0 and the indirect flag clear, the effective address is the address word.
- R6: For a two-word instruction with a nonzero tag and the indirect flag clear, the effective address is the address word plus the selected index register.
- R7: For a two-word instruction with the indirect flag set, the address is indexed first. The word read back from that location, taken to 15 bits, is the effective address.
- R8: Every memory address and effective address is reduced modulo 2^15. The counter steps from 0x7FFF to 0x0000.
- R9: `done_o` is high for exactly one clock. The gap from one strobe to the next is 3 clocks for a one-word instruction, 5 for a two-word instruction and 7 for an indirect one, given single-cycle acknowledges. The outputs stay stable during the clock after the strobe.
- R10: While `rst_n` is low there is no memory request and no strobe. Releasing reset restarts at a first-word fetch from the current counter, which reset does not change.
- R11: When `ld_en` is high, `ld_val` is written into the register chosen by `ld_sel` (0 = counter, 1..3 = index register 1..3), also during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the sequencer state |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 2 | Load target: 0 counter, 1..3 index registers |
| ld_val | input | 16 | Load value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 15 | Memory read address |
| mem_ack | input | 1 | Read acknowledge with data valid |
| mem_rdata | input | 16 | Read data |
| ea_o | output | 15 | Effective address |
| op_o | output | 5 | Opcode of the completed instruction |
| fmt_o | output | 1 | Format flag of the completed instruction |
| done_o | output | 1 | One-clock completion strobe |

## Verification
The hardest condition to create from the ports is a reset that lands between the two fetches of a two-word instruction. It shows that the counter keeps its advanced value and that the next fetch treats the address word as a fresh first word. The bench creates this by waiting until the request address moves to the second word, then pulling reset at that exact clock. Wraparound at the top of memory is reached by loading the counter just below 0x7FFF. That run places a one-word and a two-word instruction across the boundary, and its displacements and index values push sums past 2^15. Seeded random instruction words fill the rest of the program space to mix all formats, tags and indirect chains.

// File: rtl/ifa_pkg.sv
package ifa_pkg;
    typedef enum logic [1:0] {
        S_FIRST = 2'd0,
        S_ADDRW = 2'd1,
        S_PTR   = 2'd2,
        S_DONE  = 2'd3
    } ifa_state_e;
endpackage

// File: rtl/ifa_word_decode.sv
module ifa_word_decode #(
    parameter int DW    = 16,
    parameter int OPW   = 5,
    parameter int TAGW  = 2,
    parameter int DISPW = 8
) (
    input  logic [DW-1:0]    word,
    output logic [OPW-1:0]   op,
    output logic             fmt,
    output logic [TAGW-1:0]  tag,
    output logic             ind,
    output logic [DISPW-1:0] disp
);
    localparam int FMT_BIT = DW - 1 - OPW;
    localparam int TAG_TOP = FMT_BIT - 1;

    always_comb begin
        op   = word[DW-1 -: OPW];
        fmt  = word[FMT_BIT];
        tag  = word[TAG_TOP -: TAGW];
        disp = word[DISPW-1:0];
        ind  = word[DISPW-1];
    end
endmodule

// File: rtl/ifa_ea_adder.sv
module ifa_ea_adder #(
    parameter int DW    = 16,
    parameter int AW    = 15,
    parameter int TAGW  = 2,
    parameter int DISPW = 8,
    localparam int NXR  = (1 << TAGW) - 1
) (
    input  logic                    dbl,
    input  logic [TAGW-1:0]         tag,
    input  logic [DISPW-1:0]        disp,
    input  logic [DW-1:0]           addr_word,
    input  logic [AW-1:0]           ic_next,
    input  logic [NXR-1:0][DW-1:0]  xr,
    output logic [AW-1:0]           ea
);
    logic [DW-1:0] idx_val;
    logic [DW-1:0] base;
    logic [DW-1:0] offs;
    logic [DW-1:0] sum;
    logic [TAGW-1:0] slot;

    always_comb begin
        slot    = tag - TAGW'(1);
        idx_val = (tag == '0) ? '0 : xr[slot];
        if (dbl) begin
            base = idx_val;
            offs = addr_word;
        end else begin
            base = (tag == '0) ? DW'(ic_next) : idx_val;
            offs = {{(DW-DISPW){disp[DISPW-1]}}, disp};
        end
        sum = base + offs;
        ea  = sum[AW-1:0];
    end
endmodule

// File: rtl/ifa_seq.sv
module ifa_seq
    import ifa_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AW    = 15,
    parameter int OPW   = 5,
    parameter int TAGW  = 2,
    parameter int DISPW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [TAGW-1:0]  ld_sel,
    input  logic [DW-1:0]    ld_val,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output logic [AW-1:0]    ea_o,
    output logic [OPW-1:0]   op_o,
    output logic             fmt_o,
    output logic             done_o
);
    localparam int NXR = (1 << TAGW) - 1;

    typedef struct packed {
        ifa_state_e              fsm;
        logic [AW-1:0]           ic;
        logic [NXR-1:0][DW-1:0]  xr;
        logic [OPW-1:0]          op;
        logic                    fmt;
        logic [TAGW-1:0]         tag;
        logic                    ind;
        logic [AW-1:0]           ptr;
        logic [AW-1:0]           ea;
    } seq_t;

    seq_t s_q, s_d;

    logic [OPW-1:0]   dec_op;
    logic             dec_fmt;
    logic [TAGW-1:0]  dec_tag;
    logic             dec_ind;
    logic [DISPW-1:0] dec_disp;
    logic             in_addrw;
    logic [TAGW-1:0]  add_tag;
    logic [AW-1:0]    ic_inc;
    logic [AW-1:0]    ea_sum;
    logic [TAGW-1:0]  ld_slot;

    ifa_word_decode #(.DW(DW), .OPW(OPW), .TAGW(TAGW), .DISPW(DISPW)) u_dec (
        .word (mem_rdata),
        .op   (dec_op),
        .fmt  (dec_fmt),
        .tag  (dec_tag),
        .ind  (dec_ind),
        .disp (dec_disp)
    );

    assign in_addrw = (s_q.fsm == S_ADDRW);
    assign add_tag  = in_addrw ? s_q.tag : dec_tag;
    assign ic_inc   = s_q.ic + AW'(1);
    assign ld_slot  = ld_sel - TAGW'(1);

    ifa_ea_adder #(.DW(DW), .AW(AW), .TAGW(TAGW), .DISPW(DISPW)) u_add (
        .dbl       (in_addrw),
        .tag       (add_tag),
        .disp      (dec_disp),
        .addr_word (mem_rdata),
        .ic_next   (ic_inc),
        .xr        (s_q.xr),
        .ea        (ea_sum)
    );

    always_comb begin
        s_d      = s_q;
        mem_req  = 1'b0;
        mem_addr = s_q.ic;
        case (s_q.fsm)
            S_FIRST: begin
                mem_req = rst_n;
                if (rst_n && mem_ack) begin
                    s_d.ic  = ic_inc;
                    s_d.op  = dec_op;
                    s_d.fmt = dec_fmt;
                    s_d.tag = dec_tag;
                    s_d.ind = dec_ind;
                    if (dec_fmt) begin
                        s_d.fsm = S_ADDRW;
                    end else begin
                        s_d.ea  = ea_sum;
                        s_d.fsm = S_DONE;
                    end
                end
            end
            S_ADDRW: begin
                mem_req = rst_n;
                if (rst_n && mem_ack) begin
                    s_d.ic = ic_inc;
                    if (s_q.ind) begin
                        s_d.ptr = ea_sum;
                        s_d.fsm = S_PTR;
                    end else begin
                        s_d.ea  = ea_sum;
                        s_d.fsm = S_DONE;
                    end
                end
            end
            S_PTR: begin
                mem_req  = rst_n;
                mem_addr = s_q.ptr;
                if (rst_n && mem_ack) begin
                    s_d.ea  = mem_rdata[AW-1:0];
                    s_d.fsm = S_DONE;
                end
            end
            default: begin
                s_d.fsm = S_FIRST;
            end
        endcase
        if (ld_en) begin
            if (ld_sel == '0) begin
                s_d.ic = ld_val[AW-1:0];
            end else begin
                s_d.xr[ld_slot] = ld_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
        if (!rst_n) begin
            s_q.fsm <= S_FIRST;
        end
    end

    assign ea_o   = s_q.ea;
    assign op_o   = s_q.op;
    assign fmt_o  = s_q.fmt;
    assign done_o = (s_q.fsm == S_DONE);

    // R9
    done_single_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> ($stable(ea_o) && $stable(op_o) && $stable(fmt_o)));

    // R2
    request_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !ld_en) |=> (mem_req && $stable(mem_addr)));

    // R7
    pointer_read_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fsm == S_PTR && mem_ack) |=> done_o);

    // R10
    restart_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (mem_req && mem_addr == $past(s_q.ic)));
endmodule

// File: tb/ifa_seq_test.sv
`timescale 1ns/1ps
module ifa_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_sel = 2'd0;
    logic [15:0] ld_val = 16'd0;
    logic        mem_req;
    logic [14:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = 16'd0;
    logic [14:0] ea_o;
    logic [4:0]  op_o;
    logic        fmt_o;
    logic        done_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [15:0] prog [0:63];
    logic [14:0] pbase = 15'd0;
    logic [14:0] m_ic;
    logic [15:0] m_xr [0:3];

    always #2.5 clk = ~clk;

    ifa_seq uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .ea_o(ea_o), .op_o(op_o), .fmt_o(fmt_o), .done_o(done_o)
    );

    function automatic logic [15:0] memword(input logic [14:0] a);
        logic [14:0] off;
        logic [31:0] h;
        off = a - pbase;
        if (off < 15'd64) return prog[off[5:0]];
        h = {17'd0, a} * 32'h0000_9E37;
        return h[15:0] ^ 16'h3C5A;
    endfunction

    function automatic logic [15:0] mk1(input logic [4:0] op, input logic [1:0] t, input logic [7:0] d);
        return {op, 1'b0, t, d};
    endfunction

    function automatic logic [15:0] mk2(input logic [4:0] op, input logic [1:0] t, input logic ia);
        return {op, 1'b1, t, ia, 7'd0};
    endfunction

    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= memword(mem_addr);
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic load_and_reset(input logic [14:0] ic, input logic [15:0] x1,
                                  input logic [15:0] x2, input logic [15:0] x3);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            ld_en  = 1'b1;
            ld_sel = 2'(i);
            ld_val = (i == 0) ? {1'b0, ic} : (i == 1) ? x1 : (i == 2) ? x2 : x3;
            @(negedge clk);
        end
        ld_en = 1'b0;
        @(negedge clk);
        // R10: quiet during reset
        chk("R10", "done in reset", 32'(done_o), 32'd0);
        chk("R10", "req in reset", 32'(mem_req), 32'd0);
        m_ic = ic;
        m_xr[1] = x1; m_xr[2] = x2; m_xr[3] = x3;
        rst_n = 1'b1;
        #1;
        // R11 / R2: first fetch uses loaded counter
        chk("R2", "first request", 32'(mem_req), 32'd1);
        chk("R11", "first fetch address", 32'(mem_addr), 32'(ic));
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (cyc < 60) begin
            @(negedge clk);
            cyc++;
            if (done_o) break;
        end
    endtask

    task automatic run_instrs(input int n, input bit first_skip, input bit wrap_tag);
        for (int k = 0; k < n; k++) begin
            logic [15:0] w;
            logic [15:0] aw;
            logic [15:0] b;
            logic [15:0] sum;
            logic [15:0] pw;
            logic [14:0] exp_ea;
            int exp_cyc;
            int cyc;
            string rq;
            w = memword(m_ic);
            m_ic = m_ic + 15'd1;
            if (!w[10]) begin
                b = (w[9:8] == 2'd0) ? {1'b0, m_ic} : m_xr[w[9:8]];
                sum = b + {{8{w[7]}}, w[7:0]};
                exp_ea = sum[14:0];
                exp_cyc = 3;
                rq = (w[9:8] == 2'd0) ? "R3" : "R4";
            end else begin
                aw = memword(m_ic);
                m_ic = m_ic + 15'd1;
                sum = aw + ((w[9:8] == 2'd0) ? 16'd0 : m_xr[w[9:8]]);
                if (w[7]) begin
                    pw = memword(sum[14:0]);
                    exp_ea = pw[14:0];
                    exp_cyc = 7;
                    rq = "R7";
                end else begin
                    exp_ea = sum[14:0];
                    exp_cyc = 5;
                    rq = (w[9:8] == 2'd0) ? "R5" : "R6";
                end
            end
            if (wrap_tag) rq = "R8";
            wait_done(cyc);
            chk(rq, "effective address", 32'(ea_o), 32'(exp_ea));
            chk("R1", "opcode", 32'(op_o), 32'(w[15:11]));
            chk("R1", "format", 32'(fmt_o), 32'(w[10]));
            if (!(first_skip && k == 0))
                chk("R9", "strobe interval", 32'(cyc), 32'(exp_cyc));
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cyc;
        void'($urandom(32'd20240611));
        m_xr[0] = 16'd0;

        // Block A: directed formats then random words
        pbase = 15'h0100;
        for (int i = 0; i < 64; i++) prog[i] = 16'($urandom);
        prog[0]  = mk1(5'h0A, 2'd0, 8'h05);
        prog[1]  = mk1(5'h11, 2'd0, 8'h80);
        prog[2]  = mk1(5'h03, 2'd1, 8'h7F);
        prog[3]  = mk1(5'h1F, 2'd3, 8'hFE);
        prog[4]  = mk2(5'h0C, 2'd0, 1'b0);
        prog[5]  = 16'h2345;
        prog[6]  = mk2(5'h15, 2'd2, 1'b0);
        prog[7]  = 16'h1234;
        prog[8]  = mk2(5'h02, 2'd1, 1'b1);
        prog[9]  = 16'h0010;
        prog[10] = mk2(5'h19, 2'd0, 1'b1);
        prog[11] = 16'h0130;
        prog[48] = 16'hFFFF;
        load_and_reset(15'h0100, 16'h1000, 16'h0050, 16'hFFF0);
        run_instrs(60, 1'b1, 1'b0);

        // Block B: wrap at the top of memory (R8)
        pbase = 15'h7FFC;
        for (int i = 0; i < 64; i++) prog[i] = 16'($urandom);
        prog[0] = mk1(5'h01, 2'd2, 8'h20);
        prog[1] = mk1(5'h02, 2'd0, 8'h01);
        prog[2] = mk2(5'h04, 2'd0, 1'b0);
        prog[3] = 16'h9000;
        prog[4] = mk1(5'h08, 2'd0, 8'h80);
        prog[5] = mk2(5'h10, 2'd3, 1'b0);
        prog[6] = 16'h7FF0;
        load_and_reset(15'h7FFC, 16'h0001, 16'h7FF0, 16'h0040);
        run_instrs(5, 1'b1, 1'b1);
        run_instrs(20, 1'b0, 1'b0);

        // Block C: reset between the two fetches (R10)
        pbase = 15'h0200;
        for (int i = 0; i < 64; i++) prog[i] = 16'($urandom);
        prog[0] = mk2(5'h06, 2'd0, 1'b0);
        prog[1] = mk1(5'h07, 2'd0, 8'h03);
        load_and_reset(15'h0200, 16'h0300, 16'h0400, 16'h0500);
        cyc = 0;
        while (!(mem_req && mem_addr == 15'h0201) && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10", "no strobe in reset", 32'(done_o), 32'd0);
        end
        rst_n = 1'b1;
        #1;
        chk("R10", "restart fetch address", 32'(mem_addr), 32'h0201);
        chk("R10", "restart request", 32'(mem_req), 32'd1);
        m_ic = 15'h0201;
        run_instrs(12, 1'b1, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule